// File: doc/BRIEF.md
# PTP Event Header Locator

This block watches a byte-wide Ethernet stream, on either the receive or the transmit side, and works out where the PTP header of a frame begins. It recognises three encapsulations: PTP carried directly over Ethernet, PTP over UDP/IPv4, and PTP over UDP/IPv6. Each of them may carry one VLAN tag. Once the header position is known, the block captures the message type and the sequence identifier.

The stream is presented one byte per accepted cycle. A start-of-frame pulse opens a frame, a last-byte flag closes it, and an abort pulse cancels it. One cycle after the last byte, the block raises a single-cycle result strobe. Alongside the strobe it reports:

- whether a complete header was found;
- the 4-bit message type;
- the 16-bit sequence identifier;
- whether the message is a peer-delay response;
- whether the message type is enabled as an event in a per-type mask.

A timestamping unit uses these results to decide whether to keep a captured time and how to match it to its frame.

Top module: `ptp_hdr_locator`

## Requirements
- R1: A start-of-frame pulse clears every result output. The first byte may arrive in the same cycle as the pulse, and that byte is byte 0. `res_valid` is high for exactly one cycle: the cycle after the byte flagged `in_last`, giving one result per frame.
- R2: When the 16-bit big-endian value at bytes 12..13 equals `cfg_l2_etype`, the PTP header starts at byte 14. The default configuration value is 0x88F7.
- R3: A value of 0x8100 at bytes 12..13 marks a single VLAN tag. The real type is then read at bytes 16..17, and every later position moves by 4. A second 0x8100 at bytes 16..17 gives no header.
- R4: Type 0x0800 selects IPv4. The IHL field is the low nibble of byte 14(+4 with a tag), and the protocol byte at 23(+4) must equal 17. The header starts at 22 + 4*IHL (+4). An IHL below 5 gives no header.
- R5: Type 0x86DD selects IPv6. The next-header byte at 20(+4) must equal 17, and the header starts at byte 62(+4). Extension headers are not followed.
- R6: For both IP encapsulations, the UDP destination port sits big-endian at header-start minus 6 and minus 5. It must be 319 or 320, or no header is reported.
- R7: A header is reported only when the frame length in bytes is at least header-start + 34. When no header is found, `hdr_found`, `msg_type`, `seq_id`, `pdelay_resp` and `is_event` are all 0.
- R8: `msg_type` is the low nibble of the byte at header-start. `seq_id` is the big-endian pair at header-start + 30 (high byte) and + 31.
- R9: `pdelay_resp` is 1 exactly when a header is found and `msg_type` equals 3. `is_event` is 1 exactly when a header is found and `cfg_event_mask[msg_type]` is 1.
- R10: An `in_abort` pulse ends the frame without a result. Later bytes, including one flagged `in_last`, give no strobe until the next start-of-frame.
- R11: Any other type value at the type position gives no header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; clears results |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_abort | input | 1 | Cancels the current frame |
| cfg_l2_etype | input | 16 | Type value for PTP carried directly over Ethernet |
| cfg_event_mask | input | 16 | One enable bit per message type |
| res_valid | output | 1 | Result strobe, one cycle per frame |
| hdr_found | output | 1 | A complete PTP header was located |
| msg_type | output | 4 | PTP message type |
| seq_id | output | 16 | PTP sequence identifier |
| pdelay_resp | output | 1 | The message is a peer-delay response |
| is_event | output | 1 | The message type is enabled in the event mask |

## Verification
The bench builds the block with its defaults:

- `CNT_W` = 11;
- `HDR_LEN` = 34;
- `SEQ_POS` = 30;
- UDP ports 319 and 320.

With an 11-bit byte index, the deepest header start is reachable: a VLAN tag plus an IHL of 15 puts it at byte 86. The length check at header-start + 34 is exercised on both sides of the limit, so a frame exactly at the limit is accepted and one byte shorter is rejected. Because the type is a runtime configuration port, the bench can re-program it in the middle of a run. This shows a custom type being accepted while 0x88F7 is rejected. The event mask is also re-programmed, to show a non-default message type flagged as an event.

// File: rtl/ptp_hdr_locator.sv
module ptp_hdr_locator #(
  parameter int          CNT_W    = 11,
  parameter int          HDR_LEN  = 34,
  parameter int          SEQ_POS  = 30,
  parameter logic [15:0] PORT_EV  = 16'd319,
  parameter logic [15:0] PORT_GEN = 16'd320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_abort,
  input  logic [15:0] cfg_l2_etype,
  input  logic [15:0] cfg_event_mask,
  output logic        res_valid,
  output logic        hdr_found,
  output logic [3:0]  msg_type,
  output logic [15:0] seq_id,
  output logic        pdelay_resp,
  output logic        is_event
);

  typedef enum logic [1:0] {C_NONE, C_L2, C_V4, C_V6} cls_t;

  logic [CNT_W-1:0] cnt, off;
  logic             active, vlan, off_ok, port_ok;
  logic [7:0]       prev;
  logic [3:0]       mt_r;
  logic [15:0]      seq_r;
  cls_t             cls;

  wire [CNT_W-1:0] idx   = sof ? '0 : cnt;
  wire             take  = in_valid && (active || sof);
  wire [CNT_W-1:0] b     = vlan ? CNT_W'(4) : '0;
  wire [15:0]      pair  = {prev, in_data};
  wire [CNT_W:0]   need  = {1'b0, off} + (CNT_W+1)'(HDR_LEN);
  wire [CNT_W:0]   nbyte = {1'b0, idx} + 1'b1;
  wire             fnd   = !sof && (cls != C_NONE) && off_ok &&
                           (cls == C_L2 || port_ok) && (nbyte >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; off <= '1; active <= 1'b0; vlan <= 1'b0; off_ok <= 1'b0;
      port_ok <= 1'b0; prev <= '0; mt_r <= '0; seq_r <= '0; cls <= C_NONE;
      res_valid <= 1'b0; hdr_found <= 1'b0; msg_type <= '0; seq_id <= '0;
      pdelay_resp <= 1'b0; is_event <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (sof) begin
        active <= 1'b1; cnt <= '0; vlan <= 1'b0; cls <= C_NONE; off <= '1;
        off_ok <= 1'b0; port_ok <= 1'b0; mt_r <= '0; seq_r <= '0;
        hdr_found <= 1'b0; msg_type <= '0; seq_id <= '0;
        pdelay_resp <= 1'b0; is_event <= 1'b0;
      end
      if (take) begin
        prev <= in_data;
        cnt  <= (&idx) ? idx : idx + 1'b1;
        if (idx == CNT_W'(13) + b) begin
          if (!vlan && pair == 16'h8100) vlan <= 1'b1;
          else if (pair == cfg_l2_etype) begin
            cls <= C_L2; off <= CNT_W'(14) + b; off_ok <= 1'b1;
          end else if (pair == 16'h0800) cls <= C_V4;
          else if (pair == 16'h86DD) begin
            cls <= C_V6; off <= CNT_W'(62) + b; off_ok <= 1'b1;
          end
        end
        if (cls == C_V4 && idx == CNT_W'(14) + b) begin
          if (in_data[3:0] < 4'd5) cls <= C_NONE;
          else begin
            off    <= CNT_W'(22) + b + CNT_W'({in_data[3:0], 2'b00});
            off_ok <= 1'b1;
          end
        end
        if (cls == C_V4 && idx == CNT_W'(23) + b && in_data != 8'd17) cls <= C_NONE;
        if (cls == C_V6 && idx == CNT_W'(20) + b && in_data != 8'd17) cls <= C_NONE;
        if (off_ok && idx == off - CNT_W'(5))
          port_ok <= (pair == PORT_EV) || (pair == PORT_GEN);
        if (off_ok && idx == off) mt_r <= in_data[3:0];
        if (off_ok && idx == off + CNT_W'(SEQ_POS + 1)) seq_r <= pair;
        if (in_last && !in_abort) begin
          active      <= 1'b0;
          res_valid   <= 1'b1;
          hdr_found   <= fnd;
          msg_type    <= fnd ? mt_r : 4'd0;
          seq_id      <= fnd ? seq_r : 16'd0;
          pdelay_resp <= fnd && (mt_r == 4'd3);
          is_event    <= fnd && cfg_event_mask[mt_r];
        end
      end
      if (in_abort) active <= 1'b0;
    end
  end

  p_strobe_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last && !in_abort));
  p_sof_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !(in_valid && in_last)) |=> (!res_valid && !hdr_found));
  p_zero_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_found |-> (msg_type == 4'd0 && seq_id == 16'd0 && !pdelay_resp));
  p_pdelay_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pdelay_resp |-> (hdr_found && msg_type == 4'd3));
  p_event_found_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_event |-> hdr_found);
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_abort |=> !res_valid);

endmodule

// File: tb/sim_ptp_hdr_locator.sv
module sim_ptp_hdr_locator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, in_valid = 0, in_last = 0, in_abort = 0;
  logic [7:0] in_data = '0;
  logic [15:0] cfg_l2_etype = 16'h88F7, cfg_event_mask = 16'h000F;
  logic res_valid, hdr_found, pdelay_resp, is_event;
  logic [3:0] msg_type;
  logic [15:0] seq_id;

  int n_chk = 0, n_bad = 0, pulses = 0, flen = 0, foff = 0;
  logic [7:0] fr [0:255];
  logic g_found, g_pd, g_ev; logic [3:0] g_mt; logic [15:0] g_seq;

  always #4 clk = ~clk;

  ptp_hdr_locator u0 (.clk, .rst_n, .sof, .in_valid, .in_data, .in_last, .in_abort,
    .cfg_l2_etype, .cfg_event_mask, .res_valid, .hdr_found, .msg_type, .seq_id,
    .pdelay_resp, .is_event);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // kind: 0 direct, 1 IPv4, 2 IPv6
  task automatic build(input int kind, input bit vl, input int ety, input int ihl,
                       input int proto, input int port, input int mt, input int seq,
                       input int extra);
    int bb = vl ? 4 : 0;
    for (int i = 0; i < 256; i++) fr[i] = 8'(i) ^ 8'h5A;
    if (vl) begin fr[12] = 8'h81; fr[13] = 8'h00; end
    fr[12+bb] = 8'(ety >> 8); fr[13+bb] = 8'(ety);
    if (kind == 1) begin
      fr[14+bb] = 8'h40 | 8'(ihl); fr[23+bb] = 8'(proto); foff = 22 + bb + 4*ihl;
    end else if (kind == 2) begin
      fr[14+bb] = 8'h60; fr[20+bb] = 8'(proto); foff = 62 + bb;
    end else foff = 14 + bb;
    if (kind != 0) begin fr[foff-6] = 8'(port >> 8); fr[foff-5] = 8'(port); end
    fr[foff] = 8'hA0 | 8'(mt);
    fr[foff+30] = 8'(seq >> 8); fr[foff+31] = 8'(seq);
    flen = foff + 34 + extra;
  endtask

  task automatic send(input int abort_at);
    pulses = 0;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      if (i > 0 && res_valid) pulses++;
      sof = (i == 0); in_valid = 1; in_data = fr[i];
      in_last = (i == flen - 1); in_abort = (i == abort_at);
    end
    @(negedge clk);
    if (res_valid) pulses++;
    g_found = hdr_found; g_mt = msg_type; g_seq = seq_id; g_pd = pdelay_resp; g_ev = is_event;
    sof = 0; in_valid = 0; in_last = 0; in_abort = 0;
    @(negedge clk);
    if (res_valid) pulses++;
  endtask

  task automatic expect_res(input string tag, input bit f, input int mt, input int seq,
                            input bit pd, input bit ev);
    chk({tag, " R1 strobe count"}, pulses, 1);
    chk({tag, " found"}, g_found, f);
    chk({tag, " R8 msg_type"}, g_mt, mt);
    chk({tag, " R8 seq_id"}, g_seq, seq);
    chk({tag, " R9 pdelay"}, g_pd, pd);
    chk({tag, " R9 event"}, g_ev, ev);
  endtask

  task automatic t_reset;
    chk("R1 reset res_valid", res_valid, 0);
    chk("R1 reset found", hdr_found, 0);
    chk("R1 reset seq", seq_id, 0);
  endtask

  task automatic t_l2;
    build(0, 0, 16'h88F7, 0, 0, 0, 0, 16'h1234, 0); send(-1);
    expect_res("R2 direct", 1, 0, 16'h1234, 0, 1);
    build(0, 1, 16'h88F7, 0, 0, 0, 3, 16'hBEEF, 5); send(-1);
    expect_res("R3 tagged pdelay", 1, 3, 16'hBEEF, 1, 1);
    build(0, 1, 16'h8100, 0, 0, 0, 1, 16'h0101, 0); send(-1);
    expect_res("R3 double tag", 0, 0, 0, 0, 0);
  endtask

  task automatic t_v4;
    build(1, 0, 16'h0800, 5, 17, 319, 1, 16'hCAFE, 0); send(-1);
    expect_res("R4 ihl5", 1, 1, 16'hCAFE, 0, 1);
    build(1, 1, 16'h0800, 7, 17, 320, 8, 16'h7777, 2); send(-1);
    expect_res("R4 tagged ihl7", 1, 8, 16'h7777, 0, 0);
    build(1, 1, 16'h0800, 15, 17, 319, 2, 16'h8001, 0); send(-1);
    expect_res("R4 ihl15", 1, 2, 16'h8001, 0, 1);
    build(1, 0, 16'h0800, 4, 17, 319, 1, 16'h1111, 40); send(-1);
    expect_res("R4 ihl4", 0, 0, 0, 0, 0);
    build(1, 0, 16'h0800, 5, 6, 319, 1, 16'h1111, 0); send(-1);
    expect_res("R4 tcp", 0, 0, 0, 0, 0);
    build(1, 0, 16'h0800, 5, 17, 321, 1, 16'h1111, 0); send(-1);
    expect_res("R6 port321", 0, 0, 0, 0, 0);
  endtask

  task automatic t_v6;
    build(2, 0, 16'h86DD, 0, 17, 320, 2, 16'h2468, 0); send(-1);
    expect_res("R5 v6", 1, 2, 16'h2468, 0, 1);
    build(2, 1, 16'h86DD, 0, 17, 319, 11, 16'h1357, 1); send(-1);
    expect_res("R5 tagged v6", 1, 11, 16'h1357, 0, 0);
    build(2, 0, 16'h86DD, 0, 58, 319, 0, 16'h1357, 0); send(-1);
    expect_res("R5 next hdr", 0, 0, 0, 0, 0);
    build(2, 0, 16'h86DD, 0, 17, 300, 0, 16'h1357, 0); send(-1);
    expect_res("R6 v6 port", 0, 0, 0, 0, 0);
  endtask

  task automatic t_len;
    build(0, 0, 16'h88F7, 0, 0, 0, 1, 16'h4242, -1); send(-1);
    expect_res("R7 short by one", 0, 0, 0, 0, 0);
    build(1, 0, 16'h0800, 5, 17, 319, 0, 16'h4243, -1); send(-1);
    expect_res("R7 v4 short", 0, 0, 0, 0, 0);
  endtask

  task automatic t_cfg;
    build(0, 0, 16'h1234, 0, 0, 0, 0, 16'h9999, 0); send(-1);
    expect_res("R11 unknown type", 0, 0, 0, 0, 0);
    cfg_l2_etype = 16'h1234;
    send(-1);
    expect_res("R2 programmed type", 1, 0, 16'h9999, 0, 1);
    build(0, 0, 16'h88F7, 0, 0, 0, 0, 16'h9999, 0); send(-1);
    expect_res("R2 old type rejected", 0, 0, 0, 0, 0);
    cfg_l2_etype = 16'h88F7;
    cfg_event_mask = 16'h0100;
    build(0, 0, 16'h88F7, 0, 0, 0, 8, 16'h0808, 0); send(-1);
    expect_res("R9 mask type8", 1, 8, 16'h0808, 0, 1);
    cfg_event_mask = 16'h000F;
  endtask

  task automatic t_abort;
    build(0, 0, 16'h88F7, 0, 0, 0, 0, 16'h5555, 0); send(-1);
    chk("R2 before abort", g_found, 1);
    build(0, 0, 16'h88F7, 0, 0, 0, 0, 16'h6666, 0); send(20);
    chk("R10 abort no strobe", pulses, 0);
    chk("R1 sof cleared found", hdr_found, 0);
    chk("R1 sof cleared seq", seq_id, 0);
    send(-1);
    expect_res("R10 recovery", 1, 0, 16'h6666, 0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_l2; t_v4; t_v6; t_len; t_cfg; t_abort;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule